// File: doc/BRIEF.md
# Four-Element Lookup-Table Logic Cluster

This block is one tile of programmable logic. It holds four logic elements. Each element has a 4-input lookup table, a D flip-flop and an output selector. The selector presents either the registered value or the raw table value. Every input of every element comes from its own local routing selector. That selector picks one of ten shared cluster pins, the flip-flop state of any element in the cluster (its own included), or a constant zero.

The whole personality of the tile sits in one serial configuration chain. This covers the table contents, the output-select bit of each element and the routing codes of all sixteen element inputs. While `cfg_en` is high, the chain takes one bit per clock, most significant bit first. During that time every logic flip-flop is held at zero. When `cfg_en` is low, the chain keeps its contents and the cluster computes. Each element drives one cluster output pin.

Top module: `clb_cluster`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears the whole configuration chain and every logic flip-flop. After reset, `cl_out` reads 0 for any value of `pin_in`.
- R2: While `cfg_en` is high, the chain shifts once per rising edge. `cfg_din` enters at bit 0 and older bits move toward bit 131. After 132 shifts, the first bit sent sits in bit 131.
- R3: While `cfg_en` is low, the configuration does not change, whatever `cfg_din` does.
- R4: Element e owns chain bits [33e+32 : 33e]. Bits 33e+15..33e hold its truth table. The table output is truth[idx], where idx = in0 + 2·in1 + 4·in2 + 8·in3.
- R5: Chain bit 33e+16 selects the output of element e. With 0, `cl_out[e]` is the table value in the same cycle. With 1, `cl_out[e]` is the flip-flop, which captures the table value at each rising edge.
- R6: The 4-bit routing code of input j of element e sits at bits 33e+17+4j upward. Codes 0–9 pick `pin_in[code]`. Codes 10–13 pick the flip-flop state of element code−10. Codes 14 and 15 give 0.
- R7: Every logic flip-flop reads 0 after any rising edge at which `cfg_en` is high.
- R8: Through local feedback, an element can use its own state. A registered element that routes its own state to input 0 and holds the inverting table toggles on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | High: shift configuration and hold flip-flops at zero |
| cfg_din | input | 1 | Serial configuration bit, most significant first |
| pin_in | input | 10 | Shared cluster input pins |
| cl_out | output | 4 | One output per logic element |

## Verification
Four properties are checked on every cycle:
- Each shift moves `cfg_din` into the chain.
- The chain holds still while loading is off.
- The flip-flops are cleared during loading.
- The outputs read zero right after reset.

The bit layout of a loaded word, the table indexing order, the routing code decoding, the output selection and state feedback between elements only show up in the bench scenarios. There, random configurations are shifted in and every output is compared cycle by cycle with an independent model.

// File: rtl/clb_pkg.sv
// Package: shared configuration layout of one logic element.
// Assumes 4-input tables and 4-bit routing codes; the struct is packed so
// that its most significant member lies highest in the serial chain.
package clb_pkg;
    localparam int LUT_K   = 4;
    localparam int SEL_W   = 4;
    localparam int TRUTH_W = 2 ** LUT_K;

    typedef struct packed {
        logic [LUT_K*SEL_W-1:0] route;   // routing code of input j at [SEL_W*j +: SEL_W]
        logic                   use_ff;  // 1: element presents its flip-flop
        logic [TRUTH_W-1:0]     truth;   // truth table, index bit 0 = input 0
    } ble_cfg_t;

    localparam int BLE_CFG_W = $bits(ble_cfg_t);
endpackage

// File: rtl/clb_cfg_chain.sv
// Module: serial configuration store.
// Shifts one bit per clock toward the MSB while shift_en is high and holds
// otherwise. Assumes the caller sends the MSB of the image first.
module clb_cfg_chain #(
    parameter int CFG_W = 132
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [CFG_W-1:0] cfg_q
);
    // Purpose: clear on reset, shift in din while loading, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (shift_en) begin
            cfg_q <= {cfg_q[CFG_W-2:0], din};
        end
    end

    assert_shift_in_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cfg_q[0] == $past(din)));

    assert_hold_cfg_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cfg_q));
endmodule

// File: rtl/clb_route_mux.sv
// Module: local routing selector for one element input.
// Codes below N_PIN pick a cluster pin, the next N_ELEM codes pick element
// state, and any higher code yields 0. Assumes SEL_W can hold N_PIN+N_ELEM.
module clb_route_mux #(
    parameter int N_PIN  = 10,
    parameter int N_ELEM = 4,
    parameter int SEL_W  = 4
) (
    input  logic [N_PIN-1:0]  pins,
    input  logic [N_ELEM-1:0] fb,
    input  logic [SEL_W-1:0]  sel,
    output logic              y
);
    // Purpose: decode the routing code into one source bit.
    always_comb begin
        y = 1'b0;
        for (int i = 0; i < N_PIN; i++) begin
            if (sel == SEL_W'(i)) y = pins[i];
        end
        for (int i = 0; i < N_ELEM; i++) begin
            if (sel == SEL_W'(N_PIN + i)) y = fb[i];
        end
    end
endmodule

// File: rtl/clb_ble.sv
// Module: one logic element, made of a lookup table, a flip-flop and an
// output select.
// Assumes cfg is stable outside loading; hold clears the flip-flop.
module clb_ble
    import clb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  ble_cfg_t         cfg,
    input  logic [LUT_K-1:0] ins,
    output logic             q_ff,
    output logic             y
);
    logic lut_val;

    // Purpose: table read addressed by the element inputs.
    always_comb lut_val = cfg.truth[ins];

    // Purpose: state register, cleared by reset and during loading.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) q_ff <= 1'b0;
        else                q_ff <= lut_val;
    end

    // Purpose: choose the registered or the combinational result.
    always_comb y = cfg.use_ff ? q_ff : lut_val;

    assert_ff_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (q_ff == 1'b0));
endmodule

// File: rtl/clb_cluster.sv
// Module: four-element lookup-table cluster with local feedback routing.
// Assumes the configuration is loaded serially before use. Feedback taps
// each element's flip-flop, so the cluster has no combinational cycle.
module clb_cluster
    import clb_pkg::*;
#(
    parameter int N_ELEM = 4,
    parameter int N_PIN  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic [N_PIN-1:0]  pin_in,
    output logic [N_ELEM-1:0] cl_out
);
    localparam int CFG_W = N_ELEM * BLE_CFG_W;

    logic [CFG_W-1:0]  cfg_flat;
    logic [N_ELEM-1:0] ff_state;

    clb_cfg_chain #(.CFG_W(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .cfg_q    (cfg_flat)
    );

    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        ble_cfg_t         ecfg;
        logic [LUT_K-1:0] ins;

        assign ecfg = ble_cfg_t'(cfg_flat[e*BLE_CFG_W +: BLE_CFG_W]);

        for (genvar j = 0; j < LUT_K; j++) begin : g_in
            clb_route_mux #(.N_PIN(N_PIN), .N_ELEM(N_ELEM), .SEL_W(SEL_W)) u_mux (
                .pins (pin_in),
                .fb   (ff_state),
                .sel  (ecfg.route[j*SEL_W +: SEL_W]),
                .y    (ins[j])
            );
        end

        clb_ble u_ble (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (cfg_en),
            .cfg   (ecfg),
            .ins   (ins),
            .q_ff  (ff_state[e]),
            .y     (cl_out[e])
        );
    end

    assert_reset_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cl_out == '0));
endmodule

// File: tb/clb_cluster_tb.sv
`timescale 1ns/1ps
module clb_cluster_tb;
    localparam int NE = 4;
    localparam int NP = 10;
    localparam int KI = 4;
    localparam int EW = 33;
    localparam int CW = NE * EW;

    // Pin stimulus vectors walked by the main loop.
    localparam logic [NP-1:0] PIN_VEC [16] = '{
        10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h001, 10'h200, 10'h0F0, 10'h30F,
        10'h111, 10'h222, 10'h0C3, 10'h13C, 10'h3E1, 10'h01E, 10'h2D2, 10'h12D
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_din = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [NE-1:0] cl_out;

    always #2 clk = ~clk;

    clb_cluster u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .pin_in(pin_in), .cl_out(cl_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0]   m_lut  [NE];
    logic          m_rsel [NE];
    logic [3:0]    m_sel  [NE][KI];
    logic [NE-1:0] m_q;
    logic [NE-1:0] m_val;

    function automatic logic pick(input logic [3:0] s);
        if (s < NP)      return pin_in[s];
        if (s < NP + NE) return m_q[s - NP];
        return 1'b0;
    endfunction

    function automatic logic [NE-1:0] model_out();
        logic [NE-1:0] o;
        for (int e = 0; e < NE; e++) begin
            logic [3:0] idx;
            for (int j = 0; j < KI; j++) idx[j] = pick(m_sel[e][j]);
            m_val[e] = m_lut[e][idx];
            o[e] = m_rsel[e] ? m_q[e] : m_val[e];
        end
        return o;
    endfunction

    task automatic check(input string tag, input logic [NE-1:0] exp);
        n_chk++;
        if (cl_out !== exp) begin
            n_bad++;
            $display("FAIL %s: cl_out=%b expected=%b at %0t", tag, cl_out, exp, $time);
        end
    endtask

    // Serialize the model configuration (R2 layout, R4/R5/R6 fields).
    task automatic load_cfg();
        logic [CW-1:0] v;
        v = '0;
        for (int e = 0; e < NE; e++) begin
            v[e*EW +: 16] = m_lut[e];
            v[e*EW + 16]  = m_rsel[e];
            for (int j = 0; j < KI; j++) v[e*EW + 17 + 4*j +: 4] = m_sel[e][j];
        end
        @(negedge clk);
        cfg_en = 1'b1;
        for (int i = CW - 1; i >= 0; i--) begin
            cfg_din = v[i];
            @(negedge clk);
        end
        cfg_en = 1'b0;
        m_q = '0;
    endtask

    // One compute cycle: compare before the edge, then advance the model.
    task automatic run_cycle(input string tag, input logic [NP-1:0] p);
        logic [NE-1:0] exp;
        pin_in = p;
        cfg_din = 1'($urandom());   // R3: chain must ignore this
        #0.5;
        exp = model_out();
        check(tag, exp);
        @(posedge clk);
        m_q = m_val;
        @(negedge clk);
    endtask

    task automatic clear_model();
        for (int e = 0; e < NE; e++) begin
            m_lut[e] = '0;
            m_rsel[e] = 1'b0;
            for (int j = 0; j < KI; j++) m_sel[e][j] = 4'd15;
        end
        m_q = '0;
    endtask

    initial begin
        void'($urandom(32'h5EED_C1B0));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset everything reads zero.
        for (int i = 0; i < 4; i++) run_cycle("R1", PIN_VEC[i*5]);

        // R8: self-toggling element through own-state feedback.
        clear_model();
        m_lut[0] = 16'h5555; m_rsel[0] = 1'b1;
        m_sel[0][0] = 4'd10;
        for (int j = 1; j < KI; j++) m_sel[0][j] = 4'd14;
        load_cfg();
        for (int i = 0; i < 6; i++) begin
            run_cycle("R8", PIN_VEC[i]);
        end

        // R4/R5/R6/R2/R3: random configurations checked against the model.
        for (int c = 0; c < 10; c++) begin
            for (int e = 0; e < NE; e++) begin
                m_lut[e] = 16'($urandom());
                m_rsel[e] = 1'($urandom());
                for (int j = 0; j < KI; j++) m_sel[e][j] = 4'($urandom());
            end
            if (c == 0) begin
                // Pins only, combinational, so indexing is checked directly.
                for (int e = 0; e < NE; e++) begin
                    m_rsel[e] = 1'b0;
                    for (int j = 0; j < KI; j++) m_sel[e][j] = 4'(j + e);
                end
            end
            load_cfg();
            for (int k = 0; k < 32; k++) begin
                logic [NP-1:0] pv;
                pv = (k < 16) ? PIN_VEC[k] : NP'($urandom());
                run_cycle("R4_R5_R6_R2", pv);
            end
        end

        // R7: flip-flops clear once loading starts.
        clear_model();
        m_lut[0] = 16'hFFFF; m_rsel[0] = 1'b1;
        load_cfg();
        run_cycle("R5", '0);
        run_cycle("R5", '0);
        cfg_en = 1'b1;
        cfg_din = 1'b1;
        @(negedge clk);
        #0.5;
        n_chk++;
        if (cl_out[0] !== 1'b0) begin
            n_bad++;
            $display("FAIL R7: cl_out[0]=%b expected=0", cl_out[0]);
        end
        cfg_en = 1'b0;

        // R1: reset mid-run clears a loaded configuration.
        clear_model();
        m_lut[1] = 16'hFFFF;
        load_cfg();
        run_cycle("R4", PIN_VEC[3]);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        for (int i = 0; i < 3; i++) run_cycle("R1", PIN_VEC[i + 7]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule